// File: doc/BRIEF.md
# Indexed Register Bank Behind a Two-Wire Serial Target

This block is a target device on a two-wire open-drain serial bus (I2C). It watches the clock and data lines and finds START, repeated START and STOP conditions. It accepts transfers that carry its own 7-bit address, and it serves a small bank of byte registers through an internal pointer. In a write transfer, the first data byte sets the pointer. Every later byte is stored at the pointer, which then advances. In a read transfer, the block returns the byte at the pointer and advances after each byte. It continues until the controller declines a byte. The pointer survives a repeated START, so a controller can set the pointer in a short write and then turn the bus around to read. Local logic reads any register through a separate combinational port.

Both bus lines pass through a two-flop synchroniser, and an edge register follows it. One state machine then moves through these states:

- IDLE: waiting for a START.
- ADDR: shifting in the address byte.
- ACK_ADDR: driving the address acknowledge.
- WR_RX: shifting in a written byte.
- ACK_WR: driving the data acknowledge.
- RD_TX: shifting out a read byte.
- RD_ACK: sampling the controller's acknowledge.
- RD_NEXT: waiting for the clock fall before loading the next byte.
- IGNORE: silent until the next START or STOP.

The transitions are:

- START from any state goes to ADDR.
- STOP from any state goes to IDLE.
- ADDR goes to ACK_ADDR on a match, or to IGNORE on a mismatch, at the falling clock edge after eight bits.
- ACK_ADDR goes to WR_RX or RD_TX, chosen by the direction bit, at the next falling edge.
- WR_RX goes to ACK_WR after eight bits, and ACK_WR returns to WR_RX.
- RD_TX goes to RD_ACK after eight bits.
- RD_ACK goes to RD_NEXT on a sampled low, or to IGNORE on a sampled high.
- RD_NEXT goes to RD_TX at the next falling edge.

Top module: `i2cx_target`

## Requirements
- R1: After reset, sda_oe is 0, every register reads 0 on the local port, and the pointer is 0.
- R2: After a START, the block takes 8 bits MSB first on rising SCL edges. If bits 7..1 equal DEV_ADDR, it pulls SDA low for the whole ninth clock. Bit 0 = 0 selects a write and bit 0 = 1 selects a read.
- R3: In a write, the first data byte after the address is acknowledged and its low IDX_W bits become the pointer. No register changes.
- R4: Each later byte in the same write is acknowledged and stored at the pointer, and then the pointer advances by one.
- R5: In a read, the block sends the register at the pointer MSB first and advances the pointer after each byte. The pointer is kept across repeated STARTs and across separate transfers.
- R6: When the controller acknowledges (SDA low in the ninth clock), the next register follows. When it does not (SDA high), the block releases SDA and drives nothing until the next START or STOP.
- R7: When the address does not match, there is no acknowledge, no register write and no pointer change, and SDA stays released until the next START or STOP.
- R8: A START in the middle of a byte restarts address reception from bit 7.
- R9: The pointer wraps from 2^IDX_W-1 to 0.
- R10: SDA is only pulled low or released (sda_oe=1 means low), and sda_oe changes only while SCL is low.
- R11: loc_data shows the register selected by loc_idx combinationally.
- R12: A STOP releases SDA and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| loc_idx | input | IDX_W | Local read register select |
| loc_data | output | 8 | Local read data |

## Verification
A change on a bus line reaches the state machine three system clocks later: two synchroniser flops and one edge register. A drive decision therefore shows on sda_oe about four clocks after the SCL edge that causes it. The bench holds each SCL phase for at least ten clocks. It samples SDA in the middle of the high phase, so acknowledge bits and read bits are stable when it looks. Register contents are checked through the local port one clock after the loc_idx change, and only after a STOP, when every commit has long been done. A monitor at the falling clock edge flags any sda_oe change while SCL is high.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
    localparam int DW = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_WR_RX,
        ST_ACK_WR,
        ST_RD_TX,
        ST_RD_ACK,
        ST_RD_NEXT,
        ST_IGNORE
    } tgt_state_e;
endpackage

// File: rtl/i2cx_linesync.sv
module i2cx_linesync #(
    parameter int NL     = 2,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] lines_i,
    output logic [NL-1:0] lines_s,
    output logic [NL-1:0] lines_q
);
    for (genvar g = 0; g < NL; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
                last  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], lines_i[g]};
                last  <= chain[STAGES-1];
            end
        end
        assign lines_s[g] = chain[STAGES-1];
        assign lines_q[g] = last;
    end
endmodule

// File: rtl/i2cx_regbank.sv
module i2cx_regbank
    import i2cx_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] ridx_a,
    output logic [DW-1:0]    rdata_a,
    input  logic [IDX_W-1:0] ridx_b,
    output logic [DW-1:0]    rdata_b
);
    localparam int NREG = 1 << IDX_W;

    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && widx == IDX_W'(g))
                regs[g] <= wdata;
        end
    end

    assign rdata_a = regs[ridx_a];
    assign rdata_b = regs[ridx_b];

    // R4: a commit lands at the selected register
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs[$past(widx)] == $past(wdata));
endmodule

// File: rtl/i2cx_target.sv
module i2cx_target
    import i2cx_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int         IDX_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [IDX_W-1:0] loc_idx,
    output logic [DW-1:0]    loc_data
);
    localparam logic [3:0] BYTE_BITS = 4'd8;

    logic [1:0] ln_s, ln_q;
    logic scl_s, sda_s, scl_q, sda_q;
    logic scl_rise, scl_fall, start_det, stop_det;

    i2cx_linesync #(.NL(2), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i ({sda_i, scl_i}),
        .lines_s (ln_s),
        .lines_q (ln_q)
    );

    assign scl_s     = ln_s[0];
    assign sda_s     = ln_s[1];
    assign scl_q     = ln_q[0];
    assign sda_q     = ln_q[1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

    tgt_state_e       st, nxt;
    logic [3:0]       bit_cnt;
    logic [DW-1:0]    shreg, txsh;
    logic [IDX_W-1:0] idx;
    logic             idx_first;
    logic             addr_hit, rw_bit, byte_end, wr_en;
    logic [DW-1:0]    tx_byte;

    assign addr_hit = (shreg[7:1] == DEV_ADDR);
    assign rw_bit   = shreg[0];
    assign byte_end = scl_fall && (bit_cnt == BYTE_BITS);
    assign wr_en    = (st == ST_WR_RX) && byte_end && !idx_first
                      && !start_det && !stop_det;

    i2cx_regbank #(.IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .widx    (idx),
        .wdata   (shreg),
        .ridx_a  (idx),
        .rdata_a (tx_byte),
        .ridx_b  (loc_idx),
        .rdata_b (loc_data)
    );

    // next-state logic
    always_comb begin
        nxt = st;
        if (stop_det)
            nxt = ST_IDLE;
        else if (start_det)
            nxt = ST_ADDR;
        else begin
            unique case (st)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_end) nxt = addr_hit ? ST_ACK_ADDR : ST_IGNORE;
                ST_ACK_ADDR: if (scl_fall) nxt = rw_bit ? ST_RD_TX : ST_WR_RX;
                ST_WR_RX:    if (byte_end) nxt = ST_ACK_WR;
                ST_ACK_WR:   if (scl_fall) nxt = ST_WR_RX;
                ST_RD_TX:    if (byte_end) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_rise) nxt = sda_s ? ST_IGNORE : ST_RD_NEXT;
                ST_RD_NEXT:  if (scl_fall) nxt = ST_RD_TX;
                ST_IGNORE:   nxt = ST_IGNORE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // datapath and bus drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            txsh      <= '0;
            idx       <= '0;
            idx_first <= 1'b1;
            sda_oe    <= 1'b0;
        end else if (stop_det) begin
            sda_oe    <= 1'b0;
        end else if (start_det) begin
            bit_cnt   <= '0;
            sda_oe    <= 1'b0;
            idx_first <= 1'b1;
        end else begin
            unique case (st)
                ST_ADDR, ST_WR_RX: begin
                    if (scl_rise && bit_cnt < BYTE_BITS) begin
                        shreg   <= {shreg[DW-2:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_end) begin
                        bit_cnt <= '0;
                        if (st == ST_WR_RX || addr_hit)
                            sda_oe <= 1'b1;
                        if (st == ST_WR_RX) begin
                            if (idx_first) begin
                                idx       <= shreg[IDX_W-1:0];
                                idx_first <= 1'b0;
                            end else begin
                                idx <= idx + IDX_W'(1);
                            end
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (scl_fall) begin
                        if (rw_bit) begin
                            sda_oe  <= ~tx_byte[DW-1];
                            txsh    <= {tx_byte[DW-2:0], 1'b0};
                            bit_cnt <= 4'd1;
                        end else begin
                            sda_oe  <= 1'b0;
                        end
                    end
                end
                ST_ACK_WR: begin
                    if (scl_fall) sda_oe <= 1'b0;
                end
                ST_RD_TX: begin
                    if (byte_end) begin
                        sda_oe  <= 1'b0;
                        idx     <= idx + IDX_W'(1);
                        bit_cnt <= '0;
                    end else if (scl_fall) begin
                        sda_oe  <= ~txsh[DW-1];
                        txsh    <= {txsh[DW-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                end
                ST_RD_NEXT: begin
                    if (scl_fall) begin
                        sda_oe  <= ~tx_byte[DW-1];
                        txsh    <= {tx_byte[DW-2:0], 1'b0};
                        bit_cnt <= 4'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R10: the drive only changes while the synchronised clock is low
    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    // R4: a stored byte moves the pointer forward by one
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> idx == $past(idx) + IDX_W'(1));

    // R8: a START restarts address reception
    assert_start_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (st == ST_ADDR && bit_cnt == 4'd0));

    // R12: a STOP releases the line and idles
    assert_stop_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && st == ST_IDLE));

    // R7: silent while ignoring the bus
    assert_ignore_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGNORE) |-> !sda_oe);
endmodule

// File: tb/tb_i2cx_target.sv
module tb_i2cx_target;
    localparam logic [6:0] DEV = 7'h2A;
    localparam int IDX_W = 3;
    localparam int Q = 10;
    localparam int NV = 8;
    // {index, data}
    localparam logic [15:0] VEC [NV] = '{
        16'h03A5, 16'h003C, 16'h07FF, 16'h0500,
        16'h0181, 16'h067E, 16'h0255, 16'h04C3
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m_low = 1'b0;
    logic sda_oe;
    logic [IDX_W-1:0] loc_idx = '0;
    logic [7:0] loc_data;
    logic sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    int viol = 0;
    logic prev_oe = 1'b0;
    logic [7:0] model [8];

    always #10 clk = ~clk;

    assign sda_bus = ~(sda_m_low | sda_oe);

    i2cx_target #(.DEV_ADDR(DEV), .IDX_W(IDX_W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .loc_idx  (loc_idx),
        .loc_data (loc_data)
    );

    // R10 monitor: drive must not change while SCL is high
    always @(negedge clk) begin
        if (rst_n && sda_oe != prev_oe && scl_m) viol++;
        prev_oe <= sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_io(input logic b, output logic seen);
        sda_m_low = ~b;
        tick(Q);
        scl_m = 1'b1;
        tick(Q / 2);
        seen = sda_bus;
        tick(Q / 2);
        scl_m = 1'b0;
        tick(Q / 2);
    endtask

    task automatic bus_start();
        sda_m_low = 1'b0;
        tick(Q);
        scl_m = 1'b1;
        tick(Q);
        sda_m_low = 1'b1;
        tick(Q);
        scl_m = 1'b0;
        tick(Q);
    endtask

    task automatic bus_stop();
        sda_m_low = 1'b1;
        tick(Q);
        scl_m = 1'b1;
        tick(Q);
        sda_m_low = 1'b0;
        tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            b[i] = s;
        end
        bit_io(~m_ack, s);
    endtask

    task automatic loc_check(input string req, input int i, input logic [7:0] exp);
        loc_idx = IDX_W'(i);
        tick(1);
        check(req, loc_data, exp);
    endtask

    initial begin
        logic ack;
        logic [7:0] rb;
        logic s;
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        tick(3);
        rst_n = 1'b1;
        tick(3);

        // R1: reset state
        check("R1 sda_oe", sda_oe, 0);
        for (int i = 0; i < 8; i++) loc_check("R1 reg", i, 8'h00);

        // table: single-byte write, then bus read-back
        for (int v = 0; v < NV; v++) begin
            logic [2:0] ix;
            logic [7:0] dv;
            ix = VEC[v][10:8];
            dv = VEC[v][7:0];
            bus_start();
            send_byte({DEV, 1'b0}, ack); check("R2 addr ack", ack, 1);
            send_byte({5'b0, ix}, ack);  check("R3 index ack", ack, 1);
            send_byte(dv, ack);          check("R4 data ack", ack, 1);
            bus_stop();
            model[ix] = dv;
            check("R12 released", sda_oe, 0);
            loc_check("R11 local", ix, dv);
            bus_start();
            send_byte({DEV, 1'b0}, ack);
            send_byte({5'b0, ix}, ack);
            bus_start();
            send_byte({DEV, 1'b1}, ack); check("R2 read addr ack", ack, 1);
            recv_byte(1'b0, rb);         check("R5 readback", rb, dv);
            bus_stop();
        end

        // R3: index-only write leaves registers alone
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h03, ack); check("R3 index ack", ack, 1);
        bus_stop();
        loc_check("R3 not stored", 3, model[3]);
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b0, rb); check("R3 pointer loaded", rb, model[3]);
        bus_stop();

        // R4/R9: burst write wrapping past the top
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h06, ack);
        send_byte(8'h11, ack); check("R4 burst ack", ack, 1);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack);
        send_byte(8'h44, ack); check("R4 burst ack last", ack, 1);
        bus_stop();
        loc_check("R4 burst 6", 6, 8'h11);
        loc_check("R4 burst 7", 7, 8'h22);
        loc_check("R9 wrap 0", 0, 8'h33);
        loc_check("R9 wrap 1", 1, 8'h44);

        // R5/R6: burst read across wrap, ends on NACK
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h06, ack);
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b1, rb); check("R5 burst rd 6", rb, 8'h11);
        recv_byte(1'b1, rb); check("R6 ack next 7", rb, 8'h22);
        recv_byte(1'b0, rb); check("R9 rd wrap 0", rb, 8'h33);
        recv_byte(1'b0, rb); check("R6 silent after NACK", rb, 8'hFF);
        bus_stop();

        // R5: pointer persists across transfers (now at 1)
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b0, rb); check("R5 pointer kept", rb, 8'h44);
        bus_stop();

        // R7: foreign address ignored (pointer now 2)
        bus_start();
        send_byte({DEV ^ 7'h01, 1'b0}, ack); check("R7 no addr ack", ack, 0);
        send_byte(8'h05, ack);               check("R7 no data ack", ack, 0);
        send_byte(8'hEE, ack);               check("R7 no data ack 2", ack, 0);
        bus_stop();
        loc_check("R7 reg 5 kept", 5, model[5]);
        loc_check("R7 reg 2 kept", 2, model[2]);
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b0, rb); check("R7 pointer kept", rb, model[2]);
        bus_stop();

        // R8: START in mid-byte restarts address reception
        bus_start();
        bit_io(1'b1, s); bit_io(1'b0, s); bit_io(1'b1, s);
        bus_start();
        send_byte({DEV, 1'b0}, ack); check("R8 addr ack after restart", ack, 1);
        send_byte(8'h04, ack);
        send_byte(8'h99, ack);
        bus_stop();
        loc_check("R8 stored", 4, 8'h99);

        check("R10 oe changes while SCL high", viol, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule